// File: doc/BRIEF.md
# Accumulated-Hash Final Segment Detector

This block sits beside an accumulating hash engine. Software can feed one message to that engine as several separate requests, and the engine has to work out which request closes the message. A descriptor's end-of-list marker cannot settle this, because every request's list carries one. The detector looks inside the segment instead. It reads the last eight bytes as a big-endian bit count and turns that into a byte length. It compares that length with the running count of request bytes. Then it fetches the single byte where standard message padding would have to begin.

For each segment the block issues byte reads through a simple read port with one cycle of latency. It then emits a one-cycle result. The result gives the final flag, the payload length to forward to the hash core (trimmed to the padding start on a final segment), and, for a flat request that closes a cached chain, how many cached segments must be replayed and whether the current segment is appended. The block keeps the running byte total and the cached-segment count itself, and it clears both when a message completes or on reset.

Top module: `acc_pad_detect`

## Requirements
- R1: For a checked segment of length L (L >= 8), the block reads offsets L-8 up to L-1 in ascending order, one per cycle. It takes byte L-8 as the most significant byte of a 64-bit bit count, and the byte length is that count divided by 8. At most one more read follows, at the candidate offset.
- R2: The running total includes the current segment. A segment is a padding candidate only when its byte length is no greater than the running total. Otherwise no candidate read is made and the segment is not final.
- R3: The candidate offset is L minus (running total minus byte length). The segment is final exactly when the byte read at that offset equals 0x80.
- R4: On a final segment, res_len equals the candidate offset, which is below L. On any other segment, res_len equals L.
- R5: When a segment is reported final, the running total and the cached count both become zero, so the next segment is judged from an empty history. Reset also clears both.
- R6: A scatter-gather segment (seg_sg=1) is always added to the running total. Each non-final one increments the cached count, which saturates at 2^CNT_W-1.
- R7: A flat request (seg_sg=0) that arrives while the cached count is zero is not checked. The result is not final, res_len=L, and the running total is unchanged.
- R8: A flat request that arrives while the cached count is nonzero is added to the total and checked. If it is final, res_replay equals the cached count and res_append is 1 only when res_len is nonzero. In every other result, res_replay is 0 and res_append is 1.
- R9: A checked segment shorter than 8 bytes is not final and makes no reads. A candidate offset that falls outside 0..L-1 (padding size zero or larger than L) is not final and makes no candidate read.
- R10: res_valid is a single-cycle pulse. Taking the cycle where seg_start is sampled as cycle 0, the result appears in cycle 1 for unchecked or short segments, in cycle 11 when there is no candidate, and in cycle 13 when a candidate byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_start | input | 1 | Pulse that accepts a segment while the block is idle |
| seg_sg | input | 1 | 1 for a scatter-gather descriptor segment, 0 for a flat request |
| seg_len | input | LEN_W | Segment length in bytes |
| rd_en | output | 1 | Byte read request |
| rd_off | output | LEN_W | Byte offset within the segment |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| res_valid | output | 1 | One-cycle result strobe |
| res_final | output | 1 | Segment closes the message |
| res_len | output | LEN_W | Payload bytes to forward from this segment |
| res_replay | output | CNT_W | Cached segments to replay before this one |
| res_append | output | 1 | Current segment is forwarded after the replay |

## Verification
The bench counts falling edges from the cycle in which seg_start is sampled. It requires res_valid at exactly edge 1, 11 or 13, and the choice follows from its own model's decision: short or unchecked, no candidate, or candidate read. All result fields are compared only in that cycle. Read offsets are logged as they are issued and compared with the expected tail sequence and candidate offset. Whether the candidate read is present is itself part of the latency prediction.

// File: rtl/acc_pad_detect.sv
module acc_pad_detect #(
  parameter int LEN_W = 16,
  parameter int TOT_W = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_start,
  input  logic             seg_sg,
  input  logic [LEN_W-1:0] seg_len,
  output logic             rd_en,
  output logic [LEN_W-1:0] rd_off,
  input  logic [7:0]       rd_data,
  output logic             res_valid,
  output logic             res_final,
  output logic [LEN_W-1:0] res_len,
  output logic [CNT_W-1:0] res_replay,
  output logic             res_append
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] TAIL_N  = LEN_W'(8);

  typedef enum logic [2:0] {
    S_IDLE, S_TAIL, S_LAST, S_EVAL, S_CAND, S_CWAIT, S_DONE
  } st_t;

  st_t              st;
  logic [2:0]       idx;
  logic [LEN_W-1:0] len_q, off_q, trim_q;
  logic [TOT_W-1:0] tot_q;
  logic [CNT_W-1:0] cnt_q, rep_q;
  logic             sg_q, pend, fin_q, app_q;
  logic [63:0]      tail;

  logic [63:0] tot64, msg64, pad64;
  logic        in_seg, hit, accum, nf_done, f_done;
  logic [LEN_W-1:0] cand_off;

  assign tot64    = 64'(tot_q);
  assign msg64    = tail >> 3;
  assign pad64    = tot64 - msg64;
  assign in_seg   = (msg64 <= tot64) && (pad64 != 64'd0) && (pad64 <= 64'(len_q));
  assign cand_off = len_q - pad64[LEN_W-1:0];
  assign hit      = rd_data == 8'h80;
  assign accum    = seg_sg || (cnt_q != '0);
  assign nf_done  = (st == S_EVAL && !in_seg) || (st == S_CWAIT && !hit);
  assign f_done   = st == S_CWAIT && hit;

  assign rd_en  = st == S_TAIL || st == S_CAND;
  assign rd_off = (st == S_CAND) ? off_q : len_q - TAIL_N + LEN_W'(idx);

  assign res_valid  = st == S_DONE;
  assign res_final  = fin_q;
  assign res_len    = trim_q;
  assign res_replay = rep_q;
  assign res_append = app_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      len_q  <= '0;
      off_q  <= '0;
      trim_q <= '0;
      tot_q  <= '0;
      cnt_q  <= '0;
      rep_q  <= '0;
      sg_q   <= 1'b0;
      pend   <= 1'b0;
      fin_q  <= 1'b0;
      app_q  <= 1'b0;
      tail   <= '0;
    end else begin
      pend <= rd_en;
      if (pend) tail <= {tail[55:0], rd_data};

      case (st)
        S_IDLE: if (seg_start) begin
          len_q <= seg_len;
          sg_q  <= seg_sg;
          if (accum) tot_q <= tot_q + TOT_W'(seg_len);
          if (!accum || seg_len < TAIL_N) begin
            st     <= S_DONE;
            fin_q  <= 1'b0;
            trim_q <= seg_len;
            rep_q  <= '0;
            app_q  <= 1'b1;
            if (seg_sg && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          end else begin
            st  <= S_TAIL;
            idx <= '0;
          end
        end
        S_TAIL: begin
          idx <= idx + 3'd1;
          if (idx == 3'd7) st <= S_LAST;
        end
        S_LAST:  st <= S_EVAL;
        S_EVAL: begin
          if (in_seg) begin
            off_q <= cand_off;
            st    <= S_CAND;
          end else begin
            st <= S_DONE;
          end
        end
        S_CAND:  st <= S_CWAIT;
        S_CWAIT: st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      if (nf_done) begin
        fin_q  <= 1'b0;
        trim_q <= len_q;
        rep_q  <= '0;
        app_q  <= 1'b1;
        if (sg_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (f_done) begin
        fin_q  <= 1'b1;
        trim_q <= off_q;
        rep_q  <= sg_q ? '0 : cnt_q;
        app_q  <= sg_q || (off_q != '0);
        tot_q  <= '0;
        cnt_q  <= '0;
      end
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r5_final_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_final) |-> (tot_q == '0 && cnt_q == '0));

  a_r4_final_trim_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_final) |-> res_len < len_q);

  a_r4_nonfinal_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_final) |-> res_len == len_q);

  a_r1_read_in_segment: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_off < len_q);

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

  a_r8_replay_only_final: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_replay != '0) |-> (res_final && !sg_q));

endmodule

// File: tb/tb_acc_pad_detect.sv
module tb_acc_pad_detect;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int TW = 20;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seg_start = 1'b0;
  logic          seg_sg = 1'b0;
  logic [LW-1:0] seg_len = '0;
  logic          rd_en;
  logic [LW-1:0] rd_off;
  logic [7:0]    rd_data;
  logic          res_valid, res_final, res_append;
  logic [LW-1:0] res_len;
  logic [CW-1:0] res_replay;

  logic [7:0] mem [256];
  int rd_log [256];
  int rd_total = 0;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  longint tot = 0;
  int cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_pad_detect #(.LEN_W(LW), .TOT_W(TW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .seg_sg(seg_sg),
    .seg_len(seg_len), .rd_en(rd_en), .rd_off(rd_off), .rd_data(rd_data),
    .res_valid(res_valid), .res_final(res_final), .res_len(res_len),
    .res_replay(res_replay), .res_append(res_append));

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_off];

  always @(negedge clk) if (rd_en) begin
    rd_log[rd_total & 255] = int'(rd_off);
    rd_total = rd_total + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tot = 0;
    cnt = 0;
  endtask

  task automatic fill_data(input int len, input int seed);
    for (int i = 0; i < len; i++) mem[i] = 8'((i * 13 + seed * 7 + 1) & 255);
  endtask

  task automatic set_bits(input int len, input longint unsigned b);
    for (int i = 0; i < 8; i++) mem[len - 8 + i] = b[63 - 8*i -: 8];
  endtask

  task automatic pad_final(input int r, input int len, input longint unsigned msg);
    mem[r] = 8'h80;
    for (int i = r + 1; i < len - 8; i++) mem[i] = 8'h00;
    set_bits(len, msg * 8);
  endtask

  task automatic data_seg(input int seed);
    fill_data(64, seed);
    set_bits(64, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic run(input int len, input bit sg, input string req);
    bit acc, efin;
    int elat, elen, erep, eoff, base, lat;
    bit eapp;
    longint unsigned bits, msg, pad;
    acc = sg || (cnt != 0);
    if (acc) tot += len;
    efin = 0; eoff = 0;
    if (!acc || len < 8) begin
      elat = 1;
    end else begin
      bits = 0;
      for (int i = 0; i < 8; i++) bits = (bits << 8) | longint'(mem[len - 8 + i]);
      msg = bits >> 3;
      elat = 11;
      if (msg <= longint'(tot)) begin
        pad = longint'(tot) - msg;
        if (pad >= 1 && pad <= len) begin
          eoff = len - int'(pad);
          elat = 13;
          efin = (mem[eoff] == 8'h80);
        end
      end
    end
    if (efin) begin
      elen = eoff; erep = sg ? 0 : cnt; eapp = sg || (eoff != 0);
      tot = 0; cnt = 0;
    end else begin
      elen = len; erep = 0; eapp = 1;
      if (sg && cnt < CMAX) cnt++;
    end

    @(negedge clk);
    base = rd_total;
    seg_start = 1'b1; seg_sg = sg; seg_len = LW'(len);
    @(negedge clk);
    seg_start = 1'b0;
    lat = 1;
    while (!res_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == elat, "R10", "latency", lat, elat);
    chk(res_final == efin, req, "final", res_final, efin);
    chk(int'(res_len) == elen, "R4", "res_len", res_len, elen);
    chk(int'(res_replay) == erep, "R8", "replay", res_replay, erep);
    chk(res_append == eapp, "R8", "append", res_append, eapp);
    chk(rd_total - base == (elat == 1 ? 0 : (elat == 11 ? 8 : 9)), "R9",
        "read count", rd_total - base, (elat == 1 ? 0 : (elat == 11 ? 8 : 9)));
    if (elat > 1) begin
      for (int i = 0; i < 8; i++)
        chk(rd_log[(base + i) & 255] == len - 8 + i, "R1", "tail offset",
            rd_log[(base + i) & 255], len - 8 + i);
    end
    if (elat == 13)
      chk(rd_log[(base + 8) & 255] == eoff, "R3", "candidate offset",
          rd_log[(base + 8) & 255], eoff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    do_reset();
    chk(res_valid == 1'b0, "R10", "reset res_valid", res_valid, 0);
    chk(rd_en == 1'b0, "R5", "reset rd_en", rd_en, 0);

    // R3: single-segment messages of every length 0..100
    for (int m = 0; m <= 100; m++) begin
      int len;
      len = ((m + 9 + 63) / 64) * 64;
      fill_data(len, m);
      pad_final(m, len, m);
      run(len, 1'b1, "R3");
    end

    // R6 / R5: multi-segment descriptor chains
    for (int k = 1; k <= 3; k++) begin
      int rs [7] = '{0, 5, 55, 56, 63, 64, 100};
      for (int j = 0; j < 7; j++) begin
        int r, len;
        r = rs[j];
        for (int s = 0; s < k; s++) begin
          data_seg(s + j);
          run(64, 1'b1, "R6");
        end
        len = ((r + 9 + 63) / 64) * 64;
        fill_data(len, r);
        pad_final(r, len, 64 * k + r);
        run(len, 1'b1, "R5");
      end
    end

    // R8: flat request closing a cached chain
    begin
      int rs [5] = '{0, 1, 20, 55, 63};
      for (int j = 0; j < 5; j++) begin
        int r, len;
        r = rs[j];
        data_seg(1); run(64, 1'b1, "R6");
        data_seg(2); run(64, 1'b1, "R6");
        len = ((r + 9 + 63) / 64) * 64;
        fill_data(len, j);
        pad_final(r, len, 128 + r);
        run(len, 1'b0, "R8");
      end
    end

    // R9: short segments, descriptor then flat with cache
    do_reset();
    for (int n = 0; n < 8; n++) begin
      fill_data(8, n);
      run(n, 1'b1, "R9");
      run(n, 1'b0, "R9");
    end

    // R7: flat request with empty cache is never checked
    do_reset();
    fill_data(64, 3);
    pad_final(10, 64, 10);
    run(64, 1'b0, "R7");
    data_seg(4); run(64, 1'b1, "R7");
    fill_data(64, 5);
    pad_final(10, 64, 74);
    run(64, 1'b1, "R7");

    // R9 / R3: offset exactly 0 is final
    do_reset();
    fill_data(16, 6);
    mem[0] = 8'h80;
    set_bits(16, 0);
    run(16, 1'b1, "R3");

    // R9: padding size zero lands past the end
    do_reset();
    fill_data(16, 7);
    set_bits(16, 16 * 8);
    run(16, 1'b1, "R9");

    // R9: padding size one larger than the segment
    do_reset();
    data_seg(8); run(64, 1'b1, "R6");
    fill_data(16, 9);
    mem[0] = 8'h80;
    set_bits(16, 63 * 8);
    run(16, 1'b1, "R9");

    // R2: byte length larger than the running total
    do_reset();
    fill_data(64, 10);
    pad_final(10, 64, 65);
    run(64, 1'b1, "R2");

    // R3: wrong marker byte at the candidate offset
    do_reset();
    fill_data(64, 11);
    pad_final(20, 64, 20);
    mem[20] = 8'h81;
    run(64, 1'b1, "R3");

    // R6: cached count saturates
    do_reset();
    for (int s = 0; s < 9; s++) begin
      data_seg(s);
      run(64, 1'b1, "R6");
    end
    fill_data(64, 12);
    pad_final(10, 64, 9 * 64 + 10);
    run(64, 1'b0, "R6");

    // R5: reset discards the running history
    do_reset();
    data_seg(13); run(64, 1'b1, "R5");
    data_seg(14); run(64, 1'b1, "R5");
    do_reset();
    fill_data(64, 15);
    pad_final(30, 64, 30);
    run(64, 1'b1, "R5");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule